// File: doc/BRIEF.md
# Receive-FIFO Flow-Control Hysteresis Controller

This block decides when a remote transmitter must be stopped and when it may start again, based on how full a 64-entry receive FIFO is. It compares the FIFO occupancy with a halt level and a resume level. It then drives either a ready-to-receive (RTS-style) line or single-cycle requests asking a character inserter to send XOFF or XON.

The two levels come from an 8-bit threshold register. Software can write this register only while two gating bits are both set. Each nibble counts characters in steps of four. When the register is entirely zero, the block uses a fixed pair of levels chosen by a 2-bit FIFO-control trigger select instead. The block does not check that the halt level lies above the resume level. If it does not, the block simply follows its comparisons.

The controller is meant to sit next to the receive FIFO of a UART channel. Software loads the threshold register first and only then enables hardware or software flow control.

Top module: `fc_hyst_ctrl`

## Requirements
- R1: While and after a synchronous reset, the threshold register is zero, the state is not-halted, `rts_ready` is 1, and `xoff_req` and `xon_req` are 0.
- R2: In a nonzero threshold register, bits [3:0] hold the halt level and bits [7:4] hold the resume level. A field value v means 4·v characters.
- R3: A write to the threshold register takes effect at the clock edge only when `enh_en` and `bank_sel` are both 1. In any other case the write is ignored and the levels in use do not change.
- R4: When the threshold register is zero, the halt/resume levels in characters are set by `fcr_trig_sel`: 0 gives 8/4, 1 gives 16/8, 2 gives 56/48, and 3 gives 60/56.
- R5: With flow control enabled and the state not-halted, a sampled `rx_count` at or above the halt level makes the state halted at that clock edge. With `rts_mode_en` set, `rts_ready` drops to 0 at the same edge.
- R6: When the state becomes halted while `sw_mode_en` is 1, `xoff_req` is 1 for exactly one cycle.
- R7: While halted, a sampled `rx_count` at or below the resume level makes the state not-halted at that edge. `rts_ready` returns to 1, and `xon_req` pulses for one cycle if `sw_mode_en` is 1.
- R8: While halted, an `rx_count` above the resume level keeps the state halted. While not-halted, an `rx_count` below the halt level keeps it not-halted.
- R9: When both `rts_mode_en` and `sw_mode_en` are 0, the next state is not-halted and no XOFF or XON request is issued. This holds even if `rx_count` crosses the halt level in that same cycle.
- R10: An inverted setting (halt level at or below resume level) is accepted. A count lying between the two levels then toggles the state on every cycle, with an XOFF or XON pulse on each toggle in software mode.
- R11: `rts_ready` stays 1 whenever `rts_mode_en` is 0, including while halted under software flow control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | 7 | Current receive FIFO occupancy, 0 to 64 |
| thr_wr | input | 1 | Write strobe for the threshold register |
| thr_wdata | input | 8 | Write data: [7:4] resume, [3:0] halt |
| enh_en | input | 1 | Enhanced-feature enable gate for the write |
| bank_sel | input | 1 | Register-bank select gate for the write |
| fcr_trig_sel | input | 2 | Fallback level pair used when the register is zero |
| rts_mode_en | input | 1 | Hardware RTS flow control enable |
| sw_mode_en | input | 1 | Software XON/XOFF flow control enable |
| halted | output | 1 | Flow-control state, 1 = remote must stop |
| rts_ready | output | 1 | Ready-to-receive line, 0 = stop the remote |
| xoff_req | output | 1 | One-cycle request to send XOFF |
| xon_req | output | 1 | One-cycle request to send XON |

## Verification
Two events can land in the same cycle: the occupancy crossing the halt level, and both flow-control enables dropping to 0. The bench provokes this by clearing the software enable in the same cycle that `rx_count` jumps above the halt level, starting from the not-halted state. It then checks that the next state is not-halted and that no XOFF pulse appears. A second coincidence is exercised with an inverted threshold setting, where halting and releasing fall on adjacent edges. There the bench judges each edge's state, and confirms that the XOFF and XON pulses alternate with no gap.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef struct packed {
    logic [3:0] res_nib;
    logic [3:0] halt_nib;
  } fc_thr_t;

  // Fallback pairs in 4-character units, chosen by the trigger select.
  function automatic fc_thr_t fallback_thr(input logic [1:0] sel);
    fc_thr_t t;
    case (sel)
      2'd0:    begin t.halt_nib = 4'd2;  t.res_nib = 4'd1;  end
      2'd1:    begin t.halt_nib = 4'd4;  t.res_nib = 4'd2;  end
      2'd2:    begin t.halt_nib = 4'd14; t.res_nib = 4'd12; end
      default: begin t.halt_nib = 4'd15; t.res_nib = 4'd14; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/fc_thr_reg.sv
module fc_thr_reg
  import fc_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_wr,
  input  logic [REG_W-1:0] thr_wdata,
  input  logic             enh_en,
  input  logic             bank_sel,
  input  logic [1:0]       fcr_trig_sel,
  output fc_thr_t          lvl_sel
);

  logic [REG_W-1:0] thr_q;
  logic             wr_ok;

  assign wr_ok = thr_wr && enh_en && bank_sel;

  always_ff @(posedge clk) begin
    if (rst)        thr_q <= '0;
    else if (wr_ok) thr_q <= thr_wdata;
  end

  always_comb begin
    if (thr_q == '0) lvl_sel = fallback_thr(fcr_trig_sel);
    else             lvl_sel = fc_thr_t'(thr_q);
  end

  // R3: a write without both gate bits must leave the register untouched
  assert_blocked_write_R3: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !(enh_en && bank_sel)) |=> $stable(thr_q));

  // R1: reset leaves the register cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (thr_q == '0));

endmodule

// File: rtl/fc_hyst_fsm.sv
module fc_hyst_fsm
  import fc_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int STEP_SH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  fc_thr_t          lvl_sel,
  input  logic             rts_mode_en,
  input  logic             sw_mode_en,
  output logic             halted_q,
  output logic             rts_q,
  output logic             xoff_q,
  output logic             xon_q
);

  localparam int NIB_W = $bits(lvl_sel.halt_nib);

  logic [CNT_W-1:0] halt_lvl, res_lvl;
  logic             fc_on, hit_halt, hit_res, nxt_halted;

  assign halt_lvl = CNT_W'(lvl_sel.halt_nib) << STEP_SH;
  assign res_lvl  = CNT_W'(lvl_sel.res_nib)  << STEP_SH;
  assign fc_on    = rts_mode_en || sw_mode_en;
  assign hit_halt = rx_count >= halt_lvl;
  assign hit_res  = rx_count <= res_lvl;

  always_comb begin
    if (!fc_on)         nxt_halted = 1'b0;
    else if (!halted_q) nxt_halted = hit_halt;
    else                nxt_halted = !hit_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      rts_q    <= 1'b1;
      xoff_q   <= 1'b0;
      xon_q    <= 1'b0;
    end else begin
      halted_q <= nxt_halted;
      rts_q    <= !(nxt_halted && rts_mode_en);
      xoff_q   <= sw_mode_en && !halted_q && nxt_halted;
      xon_q    <= sw_mode_en && fc_on && halted_q && !nxt_halted;
    end
  end

  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!halted_q && rts_q && !xoff_q && !xon_q));

  // R5: crossing the halt level while enabled halts at the next edge
  assert_halt_cross_R5: assert property (@(posedge clk) disable iff (rst)
    (fc_on && !halted_q && hit_halt) |=> halted_q);

  // R6: XOFF request lasts a single cycle
  assert_xoff_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    xoff_q |=> !xoff_q);

  // R7: XON request lasts a single cycle
  assert_xon_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    xon_q |=> !xon_q);

  // R8: above the resume level a halted state persists
  assert_hold_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (fc_on && halted_q && (rx_count > res_lvl)) |=> halted_q);

  // R9: with both modes off the state clears and no requests appear
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !fc_on |=> (!halted_q && !xoff_q && !xon_q));

  // R11: without RTS mode the line stays asserted
  assert_rts_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rts_mode_en |=> rts_q);

  // R10: XOFF and XON never coincide
  assert_req_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xoff_q, xon_q}));

  initial assert (NIB_W + STEP_SH <= CNT_W)
    else $error("level width exceeds count width");

endmodule

// File: rtl/fc_hyst_ctrl.sv
module fc_hyst_ctrl
  import fc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int REG_W      = 8,
  parameter int STEP_SH    = 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             thr_wr,
  input  logic [REG_W-1:0] thr_wdata,
  input  logic             enh_en,
  input  logic             bank_sel,
  input  logic [1:0]       fcr_trig_sel,
  input  logic             rts_mode_en,
  input  logic             sw_mode_en,
  output logic             halted,
  output logic             rts_ready,
  output logic             xoff_req,
  output logic             xon_req
);

  fc_thr_t lvl_sel;

  fc_thr_reg #(.REG_W(REG_W)) u_thr (
    .clk          (clk),
    .rst          (rst),
    .thr_wr       (thr_wr),
    .thr_wdata    (thr_wdata),
    .enh_en       (enh_en),
    .bank_sel     (bank_sel),
    .fcr_trig_sel (fcr_trig_sel),
    .lvl_sel      (lvl_sel)
  );

  fc_hyst_fsm #(.CNT_W(CNT_W), .STEP_SH(STEP_SH)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .rx_count    (rx_count),
    .lvl_sel     (lvl_sel),
    .rts_mode_en (rts_mode_en),
    .sw_mode_en  (sw_mode_en),
    .halted_q    (halted),
    .rts_q       (rts_ready),
    .xoff_q      (xoff_req),
    .xon_q       (xon_req)
  );

endmodule

// File: tb/sim_fc_hyst_ctrl.sv
module sim_fc_hyst_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] rx_count;
  logic       thr_wr;
  logic [7:0] thr_wdata;
  logic       enh_en, bank_sel;
  logic [1:0] fcr_trig_sel;
  logic       rts_mode_en, sw_mode_en;
  logic       halted, rts_ready, xoff_req, xon_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fc_hyst_ctrl u0 (
    .clk(clk), .rst(rst), .rx_count(rx_count), .thr_wr(thr_wr),
    .thr_wdata(thr_wdata), .enh_en(enh_en), .bank_sel(bank_sel),
    .fcr_trig_sel(fcr_trig_sel), .rts_mode_en(rts_mode_en),
    .sw_mode_en(sw_mode_en), .halted(halted), .rts_ready(rts_ready),
    .xoff_req(xoff_req), .xon_req(xon_req)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // outputs packed as {halted, rts_ready, xoff_req, xon_req}
  function automatic logic [3:0] outs();
    return {halted, rts_ready, xoff_req, xon_req};
  endfunction

  task automatic idle();
    rts_mode_en = 0; sw_mode_en = 0; rx_count = 0;
    step();
  endtask

  task automatic write_thr(input logic [7:0] d);
    thr_wr = 1; thr_wdata = d;
    step();
    thr_wr = 0;
  endtask

  task automatic t_reset();
    rst = 1; step(); step();
    chk("R1 during reset", outs(), 4'b0100);
    rst = 0; step();
    chk("R1 after reset", outs(), 4'b0100);
    // zero register: fallback sel 0 gives halt 8
    fcr_trig_sel = 0; rts_mode_en = 1; rx_count = 7; step();
    chk("R1 R4 sel0 below halt", outs(), 4'b0100);
    rx_count = 8; step();
    chk("R4 R5 sel0 at halt", outs(), 4'b1000);
    rx_count = 4; step();
    chk("R4 R7 sel0 at resume", outs(), 4'b0100);
    idle();
  endtask

  task automatic t_fallback();
    fcr_trig_sel = 1; rts_mode_en = 1;
    rx_count = 15; step(); chk("R4 sel1 15", outs(), 4'b0100);
    rx_count = 16; step(); chk("R5 sel1 16", outs(), 4'b1000);
    rx_count = 9;  step(); chk("R8 sel1 9",  outs(), 4'b1000);
    rx_count = 8;  step(); chk("R7 sel1 8",  outs(), 4'b0100);
    idle();
    fcr_trig_sel = 2; rts_mode_en = 1;
    rx_count = 55; step(); chk("R4 sel2 55", outs(), 4'b0100);
    rx_count = 56; step(); chk("R4 sel2 56", outs(), 4'b1000);
    rx_count = 48; step(); chk("R4 sel2 48", outs(), 4'b0100);
    idle();
    fcr_trig_sel = 3; rts_mode_en = 1;
    rx_count = 59; step(); chk("R4 sel3 59", outs(), 4'b0100);
    rx_count = 64; step(); chk("R4 sel3 64", outs(), 4'b1000);
    rx_count = 57; step(); chk("R8 sel3 57", outs(), 4'b1000);
    rx_count = 56; step(); chk("R7 sel3 56", outs(), 4'b0100);
    idle();
    fcr_trig_sel = 0;
  endtask

  task automatic t_gating();
    enh_en = 1; bank_sel = 0; write_thr(8'h11);
    enh_en = 0; bank_sel = 1; write_thr(8'h11);
    enh_en = 0; bank_sel = 0; write_thr(8'h11);
    // if any write landed, halt level would be 4
    rts_mode_en = 1; rx_count = 4; step();
    chk("R3 gated write ignored", outs(), 4'b0100);
    rx_count = 8; step();
    chk("R3 fallback still used", outs(), 4'b1000);
    idle();
    enh_en = 1; bank_sel = 1; write_thr(8'h3A);  // halt 40, resume 12
    enh_en = 0; bank_sel = 0;
    rts_mode_en = 1;
    rx_count = 39; step(); chk("R2 below 40", outs(), 4'b0100);
    rx_count = 40; step(); chk("R2 R5 at 40", outs(), 4'b1000);
    rx_count = 13; step(); chk("R8 at 13",    outs(), 4'b1000);
    rx_count = 12; step(); chk("R2 R7 at 12", outs(), 4'b0100);
    rx_count = 30; step(); chk("R8 not-halted below halt", outs(), 4'b0100);
    idle();
  endtask

  task automatic t_sw();
    sw_mode_en = 1;
    rx_count = 40; step(); chk("R6 R11 xoff pulse", outs(), 4'b1110);
    step();               chk("R6 xoff single",    outs(), 4'b1100);
    rx_count = 12; step(); chk("R7 xon pulse",      outs(), 4'b0101);
    step();               chk("R7 xon single",     outs(), 4'b0100);
    idle();
  endtask

  task automatic t_disable();
    sw_mode_en = 1; rx_count = 50; step();
    chk("R9 setup halted", outs(), 4'b1110);
    sw_mode_en = 0; rx_count = 50; step();
    chk("R9 disable clears without xon", outs(), 4'b0100);
    // coincident halt crossing and disable from not-halted
    sw_mode_en = 1; rx_count = 0; step();
    sw_mode_en = 0; rx_count = 60; step();
    chk("R9 disable wins over crossing", outs(), 4'b0100);
    step();
    chk("R9 stays quiet", outs(), 4'b0100);
    idle();
  endtask

  task automatic t_inverted();
    enh_en = 1; bank_sel = 1; write_thr(8'h42);  // resume 16, halt 8
    enh_en = 0; bank_sel = 0;
    sw_mode_en = 1; rx_count = 10;
    step(); chk("R10 toggle halt",    outs(), 4'b1110);
    step(); chk("R10 toggle release", outs(), 4'b0101);
    step(); chk("R10 toggle halt again", outs(), 4'b1110);
    idle();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; rx_count = 0; thr_wr = 0; thr_wdata = 0; enh_en = 0;
    bank_sel = 0; fcr_trig_sel = 0; rts_mode_en = 0; sw_mode_en = 0;
    #1;
    t_reset();
    t_fallback();
    t_gating();
    t_sw();
    t_disable();
    t_inverted();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule